// File: doc/BRIEF.md
# Coherency Connect/Disconnect Handshake Controller

This block sits on the interconnect side of one coherent master's link. It runs the four-phase connection handshake with that master. The master raises `coh_req_i` to join the coherent domain and lowers it to leave. The controller answers on `coh_ack_o` once the join or the leave is complete. While the master is joined, the controller lets the snoop source issue snoops to it. It gates each issue request into a permit and counts the snoops still waiting for a response from the master.

The controller has three states. DETACHED is the reset state: acknowledge is low and no snoops may be issued. ATTACHED: acknowledge is high and snoops may be issued. DRAINING: the request has fallen and acknowledge is still high, but no new snoops are permitted while the outstanding ones complete. The transitions are:

- ATTACH (DETACHED to ATTACHED): request sampled high.
- RELEASE (ATTACHED to DRAINING): request sampled low.
- DRAINED (DRAINING to DETACHED): the outstanding count is sampled at zero.

In every other case a state holds. A request edge that arrives while the acknowledge has not yet caught up with the previous request level is a protocol violation. It is reported as a one-cycle pulse.

Top module: `coh_link_ctrl`

## Requirements
- R1: After reset the controller is DETACHED. `coh_ack_o`, `snp_grant_o` and `proto_err_o` are low and the outstanding count is zero.
- R2: In DETACHED, a clock edge that samples `coh_req_i` high moves to ATTACHED. `coh_ack_o` is high from that edge onward.
- R3: `snp_grant_o` is high only when all of these hold in the same cycle: `snp_want_i` is high, the state is ATTACHED, `coh_req_i` is high, and the outstanding count is below `MAX_OUT`.
- R4: While `coh_req_i` is low, `snp_grant_o` is low in that same cycle, even in ATTACHED.
- R5: Each edge with `snp_grant_o` high adds one to the outstanding count. Each edge with `snp_done_i` high and a nonzero count subtracts one. When both occur at the same edge, the count is unchanged.
- R6: The outstanding count never exceeds `MAX_OUT`. While it equals `MAX_OUT`, no grant is given.
- R7: In ATTACHED, an edge that samples `coh_req_i` low moves to DRAINING. `coh_ack_o` stays high in DRAINING. The first edge that samples a zero count in DRAINING moves to DETACHED, and `coh_ack_o` is low from there on.
- R8: `proto_err_o` goes high for exactly one cycle after an edge at which `coh_req_i` differs from its level sampled at the previous edge while `coh_ack_o` also differs from that previous level.
- R9: A `snp_done_i` pulse while the count is zero and no grant is given has no effect. The count does not wrap, so a following attach still allows exactly `MAX_OUT` grants before the count is full.
- R10: If `coh_req_i` rises again during DRAINING, the drain still completes. `coh_ack_o` falls at DRAINED, and ATTACH happens only at a later edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coh_req_i | input | 1 | Master's request to be in the coherent domain |
| coh_ack_o | output | 1 | Acknowledge: join or leave completed |
| snp_want_i | input | 1 | Snoop source wants to issue a snoop this cycle |
| snp_grant_o | output | 1 | Snoop issue permitted this cycle (combinational) |
| snp_done_i | input | 1 | Master completed one snoop response |
| proto_err_o | output | 1 | One-cycle handshake-violation pulse |

## Verification
Some properties are checked on every cycle:

- A grant never appears without an asserted acknowledge and request.
- A grant never appears while the request is low.
- The outstanding count never passes its ceiling.
- The acknowledge never falls while snoops were still outstanding at the previous edge.
- The acknowledge never rises unless the request was high.

Other behaviour only the bench scenarios can show:

- The exact edge at which the acknowledge rises or falls.
- That a grant and a completion at the same edge cancel.
- That stray completions while detached leave no trace.
- The timing of the error pulse when the request rises during a drain.

// File: rtl/coh_link_pkg.sv
package coh_link_pkg;

    typedef enum logic [1:0] {
        LINK_DETACHED = 2'd0,
        LINK_ATTACHED = 2'd1,
        LINK_DRAINING = 2'd2
    } link_state_e;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = 1;
        while ((1 << w) <= max_val) w++;
        return w;
    endfunction

endpackage

// File: rtl/coh_link_fsm.sv
module coh_link_fsm
    import coh_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        cnt_zero_i,
    output logic        ack_o,
    output logic        issue_ok_o,
    output link_state_e state_o
);

    link_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_DETACHED: if (req_i)      state_d = LINK_ATTACHED;
            LINK_ATTACHED: if (!req_i)     state_d = LINK_DRAINING;
            LINK_DRAINING: if (cnt_zero_i) state_d = LINK_DETACHED;
            default:                       state_d = LINK_DETACHED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINK_DETACHED;
        else        state_q <= state_d;
    end

    always_comb begin
        ack_o      = 1'b0;
        issue_ok_o = 1'b0;
        unique case (state_q)
            LINK_DETACHED: begin
                ack_o      = 1'b0;
                issue_ok_o = 1'b0;
            end
            LINK_ATTACHED: begin
                ack_o      = 1'b1;
                issue_ok_o = 1'b1;
            end
            LINK_DRAINING: begin
                ack_o      = 1'b1;
                issue_ok_o = 1'b0;
            end
            default: begin
                ack_o      = 1'b0;
                issue_ok_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

    // R2
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_i));

    // R10
    drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LINK_DRAINING && !cnt_zero_i) |=> state_q == LINK_DRAINING);

endmodule

// File: rtl/coh_snoop_tracker.sv
module coh_snoop_tracker #(
    parameter int unsigned MAX_OUT = 4,
    localparam int unsigned CNT_W  = coh_link_pkg::cnt_width(MAX_OUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             done_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o,
    output logic             zero_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

    logic [CNT_W-1:0] cnt_q;
    logic             dec;

    assign dec    = done_i && (cnt_q != '0);
    assign full_o = (cnt_q == CNT_MAX);
    assign zero_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc_i, dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == '0 && !$past(inc_i)) |-> cnt_q == '0);

endmodule

// File: rtl/coh_req_monitor.sv
module coh_req_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ack_i,
    output logic err_o
);

    logic req_q;
    logic err_q;
    logic violation;

    assign violation = (req_i != req_q) && (ack_i != req_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            req_q <= req_i;
            err_q <= violation;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/coh_link_ctrl.sv
module coh_link_ctrl
    import coh_link_pkg::*;
#(
    parameter int unsigned MAX_OUT = 4,
    localparam int unsigned CNT_W  = cnt_width(MAX_OUT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic coh_req_i,
    output logic coh_ack_o,
    input  logic snp_want_i,
    output logic snp_grant_o,
    input  logic snp_done_i,
    output logic proto_err_o
);

    logic             issue_ok;
    logic             cnt_full;
    logic             cnt_zero;
    logic [CNT_W-1:0] cnt;
    link_state_e      state;

    coh_link_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (coh_req_i),
        .cnt_zero_i (cnt_zero),
        .ack_o      (coh_ack_o),
        .issue_ok_o (issue_ok),
        .state_o    (state)
    );

    assign snp_grant_o = snp_want_i && issue_ok && coh_req_i && !cnt_full;

    coh_snoop_tracker #(.MAX_OUT(MAX_OUT)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (snp_grant_o),
        .done_i (snp_done_i),
        .cnt_o  (cnt),
        .full_o (cnt_full),
        .zero_o (cnt_zero)
    );

    coh_req_monitor u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (coh_req_i),
        .ack_i (coh_ack_o),
        .err_o (proto_err_o)
    );

    // R3
    grant_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_grant_o |-> (coh_ack_o && state == LINK_ATTACHED));

    // R4
    grant_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !coh_req_i |-> !snp_grant_o);

    // R7
    ack_fall_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coh_ack_o) |-> ($past(cnt) == '0));

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> $past(coh_req_i) != $past(coh_req_i, 2));

endmodule

// File: tb/coh_link_ctrl_tb.sv
module coh_link_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXO       = 3;
    localparam int NVEC       = 22;

    // {req, want, done, exp_ack, exp_grant, exp_err}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b010_000, // 0  R1 detached, want ignored
        6'b110_000, // 1  R2 req seen
        6'b110_110, // 2  R2 ack high, R3 grant
        6'b110_110, // 3  R5 cnt 2
        6'b110_110, // 4  cnt 3
        6'b110_100, // 5  R6 full
        6'b111_100, // 6  R6 still full at edge
        6'b111_110, // 7  R5 cancel
        6'b101_100, // 8  cnt 1
        6'b010_100, // 9  R4 req low blocks
        6'b010_100, // 10 R7 draining, ack held
        6'b001_100, // 11 cnt -> 0
        6'b000_100, // 12 R7 drained at this edge
        6'b000_000, // 13 R7 ack low
        6'b100_000, // 14 attach
        6'b110_110, // 15 cnt 1
        6'b000_100, // 16 release
        6'b110_100, // 17 R8 req rises in drain
        6'b101_101, // 18 R8 pulse
        6'b100_100, // 19 R10 drained, ack still high
        6'b100_000, // 20 R10 ack low before reattach
        6'b110_110  // 21 R10 reattached
    };

    logic clk = 1'b0;
    logic rst_n;
    logic coh_req, snp_want, snp_done;
    logic coh_ack, snp_grant, proto_err;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_link_ctrl #(.MAX_OUT(MAXO)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .coh_req_i   (coh_req),
        .coh_ack_o   (coh_ack),
        .snp_want_i  (snp_want),
        .snp_grant_o (snp_grant),
        .snp_done_i  (snp_done),
        .proto_err_o (proto_err)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic w, input logic d);
        @(negedge clk);
        coh_req  = r;
        snp_want = w;
        snp_done = d;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int grants;
        rst_n = 1'b0;
        coh_req = 0; snp_want = 0; snp_done = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 ack after reset", coh_ack, 1'b0);
        check("R1 grant after reset", snp_grant, 1'b0);
        check("R1 err after reset", proto_err, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            check($sformatf("vec%0d ack R2/R7/R10", i), coh_ack, VEC[i][2]);
            check($sformatf("vec%0d grant R3/R4/R6", i), snp_grant, VEC[i][1]);
            check($sformatf("vec%0d err R8", i), proto_err, VEC[i][0]);
        end

        // R1: reset in the middle of an attached link
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid reset ack", coh_ack, 1'b0);
        check("R1 mid reset grant", snp_grant, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        coh_req = 0; snp_want = 0; snp_done = 0;

        // R9: stray completions while detached must not wrap the count
        step(0, 0, 1);
        step(0, 0, 1);
        check("R9 ack stays low", coh_ack, 1'b0);
        step(1, 0, 0);
        grants = 0;
        for (int k = 0; k < MAXO + 2; k++) begin
            step(1, 1, 0);
            if (snp_grant) grants++;
        end
        total++;
        if (grants != MAXO) begin
            bad++;
            $display("FAIL R9/R6 grants got=%0d exp=%0d", grants, MAXO);
        end

        // R7: release with count full keeps ack until drained
        step(0, 1, 0);
        check("R4 grant off with req low", snp_grant, 1'b0);
        for (int k = 0; k < MAXO; k++) begin
            step(0, 0, 1);
            check("R7 ack held while draining", coh_ack, 1'b1);
        end
        step(0, 0, 0);
        check("R7 ack held at drained edge", coh_ack, 1'b1);
        step(0, 0, 0);
        check("R7 ack low after drain", coh_ack, 1'b0);
        check("R8 no err on clean exit", proto_err, 1'b0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule